// File: doc/BRIEF.md
# I2C SCL Bit-Timing Divider

This block derives the SCL waveform of an I2C master from the peripheral clock. A 12-bit divider value CC and a mode bit select the bit rate. The mode bit chooses between a standard-mode timing with a nearly symmetric duty cycle and a fast-mode timing whose low phase takes about two thirds of the period. The divider and the mode bit are held in two 8-bit configuration registers that are written through a small write port.

The byte controller raises `run_i` to request clock periods. The block answers with registered phase enables for the low and high halves of SCL and with two single-cycle strobes. The drive strobe falls in the middle of the low phase, where SDA may change. The sample strobe falls in the middle of the high phase, where SDA is read. The active lengths are captured at the start of each period. A register write therefore never shortens or stretches a period that is already running. A divider below 2 is clamped to 2, so the counter always advances.

Top module: `i2c_scl_timebase`

## Requirements
- R1: After reset both registers hold 0x00, which selects standard mode with CC=0. The outputs are idle: `scl_high_o`=1, `scl_low_o`=0, `clk_active_o`=0, and both strobes are 0. A period run with the reset configuration has a low phase of 5 cycles and a high phase of 4 cycles.
- R2: Register address 0 holds the mode bit in bit 7 (1 = fast) and CC[6:0] in bits 6:0. Register address 1 holds CC[11:7] in bits 4:0. Bits 7:5 of address 1 have no effect on the timing.
- R3: In standard mode the low phase lasts CC+3 cycles and the high phase lasts CC+2 cycles, for a period of 2·CC+5 cycles.
- R4: In fast mode the low phase lasts 2·CC+4 cycles and the high phase lasts CC+2 cycles, for a period of 3·CC+6 cycles.
- R5: A CC value of 0 or 1 is timed exactly as CC=2 in the selected mode.
- R6: Each low phase carries exactly one `drive_tick_o` pulse of one cycle. It falls at cycle offset floor(L/2) of the low phase, where L is the low length and offsets count from 0.
- R7: Each high phase carries exactly one `sample_tick_o` pulse of one cycle. It falls at offset floor(H/2) of the high phase, where H is the high length.
- R8: A register write during a period leaves that period's lengths unchanged. The new lengths apply from the next period start.
- R9: When idle with `run_i`=1, a low phase begins. At the end of each high phase the block starts a new period if `run_i` is 1, and otherwise returns to idle. In idle SCL is high, `clk_active_o` is 0 and no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Register select: 0 mode/low divider bits, 1 upper divider bits |
| cfg_wdata | input | 8 | Write data |
| run_i | input | 1 | Request for SCL periods from the byte controller |
| scl_low_o | output | 1 | SCL low-phase enable |
| scl_high_o | output | 1 | SCL high (released) enable, also asserted in idle |
| clk_active_o | output | 1 | A period is in progress |
| drive_tick_o | output | 1 | Mid-low strobe for SDA update |
| sample_tick_o | output | 1 | Mid-high strobe for SDA sampling |

## Verification
The end of a high phase decides two things in the same cycle: whether another period starts, and whether freshly computed lengths replace the captured ones. The bench rewrites the divider early in the first period of a running burst. It then withdraws `run_i` during a later period. It checks that the first period keeps the old lengths, that every later period uses the new ones, and that the stream stops after exactly the queued number of periods with no strobe in idle. A scoreboard measures each low and high phase and each strobe position, and compares them with lengths computed from the mode and divider formulas.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  localparam logic CFG_ADDR_CTL = 1'b0;
  localparam logic CFG_ADDR_EXT = 1'b1;
endpackage

// File: rtl/sclgen_cfg_regs.sv
module sclgen_cfg_regs
  import sclgen_pkg::*;
#(
  parameter int CCW = 12,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic           addr,
  input  logic [DW-1:0]  wdata,
  output logic [CCW-1:0] cc_o,
  output logic           fast_o
);
  localparam int LO_W = DW - 1;
  localparam int HI_W = CCW - LO_W;

  logic [DW-1:0]   ctl_q;
  logic [HI_W-1:0] ext_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      ext_q <= '0;
    end else if (we) begin
      if (addr == CFG_ADDR_CTL) ctl_q <= wdata;
      else                      ext_q <= wdata[HI_W-1:0];
    end
  end

  assign cc_o   = {ext_q, ctl_q[LO_W-1:0]};
  assign fast_o = ctl_q[DW-1];
endmodule

// File: rtl/sclgen_len_calc.sv
module sclgen_len_calc #(
  parameter int CCW     = 12,
  parameter int LW      = CCW + 2,
  parameter int MIN_CC  = 2,
  parameter bit FAST_EN = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [CCW-1:0] cc,
  input  logic           fast,
  output logic [LW-1:0]  low_len,
  output logic [LW-1:0]  high_len,
  output logic [LW-1:0]  low_mid,
  output logic [LW-1:0]  high_mid
);
  localparam logic [CCW-1:0] MIN_V   = CCW'(MIN_CC);
  localparam logic [LW-1:0]  RST_LO  = LW'(MIN_CC + 3);
  localparam logic [LW-1:0]  RST_HI  = LW'(MIN_CC + 2);

  logic          fast_sel;
  logic [LW-1:0] cc_eff;
  logic [LW-1:0] lo_n;
  logic [LW-1:0] hi_n;

  generate
    if (FAST_EN) begin : g_fast
      assign fast_sel = fast;
    end else begin : g_std_only
      assign fast_sel = 1'b0;
    end
  endgenerate

  always_comb begin
    cc_eff = (cc < MIN_V) ? LW'(MIN_V) : LW'(cc);
    hi_n   = cc_eff + LW'(2);
    if (fast_sel) lo_n = (cc_eff << 1) + LW'(4);
    else          lo_n = cc_eff + LW'(3);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      low_len  <= RST_LO;
      high_len <= RST_HI;
      low_mid  <= RST_LO >> 1;
      high_mid <= RST_HI >> 1;
    end else begin
      low_len  <= lo_n;
      high_len <= hi_n;
      low_mid  <= lo_n >> 1;
      high_mid <= hi_n >> 1;
    end
  end

  a_r5_min_len: assert property (@(posedge clk) disable iff (rst)
    (low_len >= RST_LO) && (high_len >= RST_HI));
  a_r4_fast_ratio: assert property (@(posedge clk) disable iff (rst)
    (low_len > high_len + LW'(1)) |-> (low_len == (high_len << 1)));
endmodule

// File: rtl/sclgen_phase_ctr.sv
module sclgen_phase_ctr
  import sclgen_pkg::*;
#(
  parameter int LW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [LW-1:0] low_len,
  input  logic [LW-1:0] high_len,
  input  logic [LW-1:0] low_mid,
  input  logic [LW-1:0] high_mid,
  output logic          scl_low_o,
  output logic          scl_high_o,
  output logic          active_o,
  output logic          drive_tick_o,
  output logic          sample_tick_o
);
  phase_e        phase, nphase;
  logic [LW-1:0] cnt, ncnt;
  logic [LW-1:0] act_low, act_high, act_lmid, act_hmid;
  logic          load;
  logic [LW-1:0] lmid_use;

  always_comb begin
    nphase = phase;
    ncnt   = cnt + 1'b1;
    load   = 1'b0;
    case (phase)
      PH_IDLE: begin
        ncnt = '0;
        if (run) begin
          nphase = PH_LOW;
          load   = 1'b1;
        end
      end
      PH_LOW: begin
        if (cnt == act_low - 1'b1) begin
          nphase = PH_HIGH;
          ncnt   = '0;
        end
      end
      PH_HIGH: begin
        if (cnt == act_high - 1'b1) begin
          ncnt = '0;
          if (run) begin
            nphase = PH_LOW;
            load   = 1'b1;
          end else begin
            nphase = PH_IDLE;
          end
        end
      end
      default: begin
        nphase = PH_IDLE;
        ncnt   = '0;
      end
    endcase
    lmid_use = load ? low_mid : act_lmid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase         <= PH_IDLE;
      cnt           <= '0;
      act_low       <= '1;
      act_high      <= '1;
      act_lmid      <= '0;
      act_hmid      <= '0;
      scl_low_o     <= 1'b0;
      scl_high_o    <= 1'b1;
      active_o      <= 1'b0;
      drive_tick_o  <= 1'b0;
      sample_tick_o <= 1'b0;
    end else begin
      phase <= nphase;
      cnt   <= ncnt;
      if (load) begin
        act_low  <= low_len;
        act_high <= high_len;
        act_lmid <= low_mid;
        act_hmid <= high_mid;
      end
      scl_low_o     <= (nphase == PH_LOW);
      scl_high_o    <= (nphase != PH_LOW);
      active_o      <= (nphase != PH_IDLE);
      drive_tick_o  <= (nphase == PH_LOW)  && (ncnt == lmid_use);
      sample_tick_o <= (nphase == PH_HIGH) && (ncnt == act_hmid);
    end
  end

  a_r6_drive_in_low: assert property (@(posedge clk) disable iff (rst)
    drive_tick_o |-> (scl_low_o && phase == PH_LOW));
  a_r7_sample_in_high: assert property (@(posedge clk) disable iff (rst)
    sample_tick_o |-> (scl_high_o && active_o && phase == PH_HIGH));
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LOW) |-> (cnt < act_low));
  a_r8_len_hold: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && $past(phase) != PH_IDLE && !$past(load))
      |-> ($stable(act_low) && $stable(act_high)));
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !active_o |-> (scl_high_o && !drive_tick_o && !sample_tick_o));
endmodule

// File: rtl/i2c_scl_timebase.sv
module i2c_scl_timebase #(
  parameter int CCW     = 12,
  parameter int DW      = 8,
  parameter int MIN_CC  = 2,
  parameter bit FAST_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          run_i,
  output logic          scl_low_o,
  output logic          scl_high_o,
  output logic          clk_active_o,
  output logic          drive_tick_o,
  output logic          sample_tick_o
);
  localparam int LW = CCW + 2;

  logic [CCW-1:0] cc;
  logic           fast;
  logic [LW-1:0]  low_len, high_len, low_mid, high_mid;

  sclgen_cfg_regs #(.CCW(CCW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .cc_o(cc), .fast_o(fast)
  );

  sclgen_len_calc #(.CCW(CCW), .LW(LW), .MIN_CC(MIN_CC), .FAST_EN(FAST_EN)) u_calc (
    .clk(clk), .rst(rst), .cc(cc), .fast(fast),
    .low_len(low_len), .high_len(high_len), .low_mid(low_mid), .high_mid(high_mid)
  );

  sclgen_phase_ctr #(.LW(LW)) u_ctr (
    .clk(clk), .rst(rst), .run(run_i),
    .low_len(low_len), .high_len(high_len), .low_mid(low_mid), .high_mid(high_mid),
    .scl_low_o(scl_low_o), .scl_high_o(scl_high_o), .active_o(clk_active_o),
    .drive_tick_o(drive_tick_o), .sample_tick_o(sample_tick_o)
  );
endmodule

// File: tb/i2c_scl_timebase_tb.sv
module i2c_scl_timebase_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic       cfg_addr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       run_i = 1'b0;
  logic       scl_low_o, scl_high_o, clk_active_o, drive_tick_o, sample_tick_o;

  always #5 clk = ~clk;

  i2c_scl_timebase u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .run_i(run_i), .scl_low_o(scl_low_o), .scl_high_o(scl_high_o),
    .clk_active_o(clk_active_o), .drive_tick_o(drive_tick_o), .sample_tick_o(sample_tick_o)
  );

  typedef struct { int lo; int hi; string tag; } exp_t;
  exp_t exp_q[$];

  int total = 0, bad = 0, done_cnt = 0, idle_viol = 0, cycles = 0;
  int lcnt = 0, hcnt = 0, d_n = 0, s_n = 0, d_at = -1, s_at = -1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int exp_lo(input int cc, input bit fast);
    int c = (cc < 2) ? 2 : cc;
    return fast ? 2 * c + 4 : c + 3;
  endfunction

  function automatic int exp_hi(input int cc);
    int c = (cc < 2) ? 2 : cc;
    return c + 2;
  endfunction

  task automatic finalize();
    exp_t e;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R9", "unexpected period", 1, 0);
    end else begin
      e = exp_q.pop_front();
      chk(lcnt == e.lo, e.tag, "low length", lcnt, e.lo);
      chk(hcnt == e.hi, e.tag, "high length", hcnt, e.hi);
      chk(d_n == 1, "R6", "drive tick count", d_n, 1);
      chk(d_at == e.lo / 2, "R6", "drive tick offset", d_at, e.lo / 2);
      chk(s_n == 1, "R7", "sample tick count", s_n, 1);
      chk(s_at == e.hi / 2, "R7", "sample tick offset", s_at, e.hi / 2);
    end
    done_cnt++;
    lcnt = 0; hcnt = 0; d_n = 0; s_n = 0; d_at = -1; s_at = -1;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (clk_active_o && scl_low_o) begin
        if (hcnt > 0) finalize();
        if (drive_tick_o) begin d_n++; d_at = lcnt; end
        if (sample_tick_o) s_n++;
        lcnt++;
      end else if (clk_active_o) begin
        if (sample_tick_o) begin s_n++; s_at = hcnt; end
        if (drive_tick_o) d_n++;
        hcnt++;
      end else begin
        if (hcnt > 0 || lcnt > 0) finalize();
        if (drive_tick_o || sample_tick_o || !scl_high_o || scl_low_o) idle_viol++;
      end
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push_cfg(input int ctl, input int ext, input int n, input string tag);
    int cc = ((ext & 31) << 7) | (ctl & 127);
    bit fast = ctl[7];
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.lo = exp_lo(cc, fast); e.hi = exp_hi(cc); e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic burst(input int n);
    int base = done_cnt;
    @(negedge clk);
    run_i = 1'b1;
    if (n == 1) begin
      @(negedge clk);
    end else begin
      wait (done_cnt == base + n - 1);
      @(negedge clk);
    end
    run_i = 1'b0;
    wait (done_cnt == base + n);
    repeat (2) @(negedge clk);
    chk(scl_high_o && !scl_low_o && !clk_active_o, "R9", "idle after burst",
        {29'd0, scl_high_o, scl_low_o, clk_active_o}, 4);
  endtask

  task automatic cfg_burst(input int ctl, input int ext, input int n, input string tag);
    wr(1'b0, 8'(ctl));
    wr(1'b1, 8'(ext));
    repeat (3) @(negedge clk);
    push_cfg(ctl, ext, n, tag);
    burst(n);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(scl_high_o && !scl_low_o && !clk_active_o && !drive_tick_o && !sample_tick_o,
        "R1", "reset outputs",
        {27'd0, scl_high_o, scl_low_o, clk_active_o, drive_tick_o, sample_tick_o}, 16);
    // R1: default config period 5/4
    push_cfg(0, 0, 1, "R1");
    burst(1);
    // R3 standard, CC=10
    cfg_burst(8'h0A, 0, 3, "R3");
    // R4 fast, CC=10
    cfg_burst(8'h8A, 0, 2, "R4");
    // R4 fast with upper divider bits, CC=273
    cfg_burst(8'h91, 2, 2, "R4");
    // R5 clamp in fast mode (CC=1) and standard mode (CC=0)
    cfg_burst(8'h81, 0, 2, "R5");
    cfg_burst(8'h00, 0, 2, "R5");
    // R2 ignored upper bits of ext register: 0xE3 acts like 0x03, CC=389
    cfg_burst(8'h05, 8'hE3, 2, "R2");
    // R8 mid-period divider change
    begin
      int base;
      wr(1'b0, 8'h0A);
      wr(1'b1, 8'h00);
      repeat (3) @(negedge clk);
      push_cfg(8'h0A, 0, 1, "R8");
      push_cfg(8'h14, 0, 2, "R8");
      base = done_cnt;
      run_i = 1'b1;
      wait (clk_active_o);
      repeat (2) @(negedge clk);
      wr(1'b0, 8'h14);
      wait (done_cnt == base + 2);
      @(negedge clk);
      run_i = 1'b0;
      wait (done_cnt == base + 3);
      repeat (2) @(negedge clk);
    end
    chk(exp_q.size() == 0, "R9", "scoreboard drained", exp_q.size(), 0);
    chk(idle_viol == 0, "R9", "idle strobes/levels", idle_viol, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule